// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. Each raw request line is sampled on every clock. A per-line trigger select decides how the line is captured. An edge-mode line records a request on a low-to-high transition. A level-mode line simply mirrors its input. The captured requests are combined with a mask register. Among the candidates that remain, the block picks the line nearest to a programmable rotating priority base. It reports that line only when it outranks every interrupt that is already in service.

The surrounding logic drives the block through a few strobes:
- `ack` moves the reported line into service.
- `eoi` retires the highest-priority line in service and, when asked, rotates the base behind it.
- `mask_wr`, `trig_wr` and `base_wr` load the configuration registers.
- The `special_mask` and `nested_mode` flags change how the in-service set is compared.
- `ctl_clear` is a controller re-initialisation. It clears the dynamic state but keeps the trigger selection.

Top module: `irq_rotary_resolver`

## Requirements
- R1: After `rst_n` is low, or after a one-cycle `ctl_clear` pulse, the requests, mask, in-service set and base are all zero, and `pend_valid` is 0.
- R2: An edge-mode line (trigger bit 0) raises a request only on a rising input. Holding the input high after the request was acknowledged raises no new request. A low input drops both the request and the edge history.
- R3: A level-mode line (trigger bit 1) has a request that follows the input one cycle later, and `ack` does not clear it.
- R4: A line whose mask bit is 1 is never reported. Clearing the mask bit makes it eligible again.
- R5: The rank of line i is (i − base) mod 8, with rank 0 the strongest. `pend_irq` is the unmasked requesting line with the smallest rank.
- R6: A candidate is reported only when its rank is strictly below the rank of the strongest in-service line. An equal or weaker rank is held back.
- R7: `ack` while `pend_valid` is 1 puts `pend_irq` into service and clears its request if that line is in edge mode. `ack` while `pend_valid` is 0 changes nothing.
- R8: `eoi` removes the strongest in-service line from service. With `eoi_rotate` set, the base becomes that line + 1 (mod 8). `eoi` is ignored in a cycle that also carries `ack`.
- R9: With `special_mask` set, in-service lines whose mask bit is 1 take no part in the in-service comparison.
- R10: With `nested_mode` set on a master instance (`IS_MASTER`=1), in-service line `CASCADE_LINE` (2 by default) takes no part in the in-service comparison.
- R11: `ctl_clear` leaves the trigger-select register unchanged. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| ctl_clear | input | 1 | Synchronous re-initialisation, keeps trigger select |
| req_in | input | LINES | Raw interrupt request lines |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | LINES | New mask value, 1 = line masked |
| trig_wr | input | 1 | Load strobe for the trigger-select register |
| trig_data | input | LINES | New trigger select, 1 = level, 0 = edge |
| base_wr | input | 1 | Load strobe for the priority base |
| base_data | input | IDXW | New priority base (line of rank 0) |
| special_mask | input | 1 | Exclude masked lines from the in-service comparison |
| nested_mode | input | 1 | Exclude the cascade line from the in-service comparison (master only) |
| ack | input | 1 | Acknowledge the reported line |
| eoi | input | 1 | End of interrupt for the strongest in-service line |
| eoi_rotate | input | 1 | With `eoi`, rotate the base behind the retired line |
| pend_valid | output | 1 | A line is being reported |
| pend_irq | output | IDXW | Reported line number |

## Verification
The priority selection is tried with several base values, from 0 through 7, against the same pair of requesting lines. This shows that the rank is taken relative to the base and not from the raw line number. Candidates are placed above, equal to and below the in-service rank. This separates the strict comparison from a non-strict one. Several lines are put in service at once and then retired one by one with end-of-interrupt, which shows which in-service bit is removed. Edge and level lines get the same pattern of raise, acknowledge, retire and hold high, which tells the two capture modes apart. Both compare-exclusion flags are toggled while a masked line or the cascade line is in service, so the same request shows as held back and then as reported.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
   typedef enum logic {
      TRIG_EDGE  = 1'b0,
      TRIG_LEVEL = 1'b1
   } trig_mode_e;
endpackage

// File: rtl/irqr_req_latch.sv
module irqr_req_latch
   import irqr_pkg::*;
#(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [LINES-1:0] line_in,
   input  logic [LINES-1:0] trig_sel,
   input  logic [LINES-1:0] drop_req,
   output logic [LINES-1:0] req_q
);
   logic [LINES-1:0] last_q;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic req_b, last_b;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_b  <= 1'b0;
            last_b <= 1'b0;
         end else if (clr) begin
            req_b  <= 1'b0;
            last_b <= 1'b0;
         end else if (trig_mode_e'(trig_sel[i]) == TRIG_LEVEL) begin
            req_b  <= line_in[i];
            last_b <= line_in[i];
         end else if (line_in[i]) begin
            last_b <= 1'b1;
            if (!last_b)
               req_b <= 1'b1;
            else if (drop_req[i])
               req_b <= 1'b0;
         end else begin
            req_b  <= 1'b0;
            last_b <= 1'b0;
         end
      end
      assign req_q[i]  = req_b;
      assign last_q[i] = last_b;
   end

   // R2: a new edge-mode request needs a low history bit
   assert_edge_needs_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((req_q & ~$past(req_q) & ~$past(trig_sel) & $past(last_q)) == '0));

   // R3: level-mode requests mirror the sampled input
   assert_level_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (((req_q ^ $past(line_in)) & $past(trig_sel)) == '0));
endmodule

// File: rtl/irqr_rank.sv
module irqr_rank #(
   parameter int LINES = 8,
   parameter int IDXW  = $clog2(LINES)
) (
   input  logic [LINES-1:0] vec,
   input  logic [IDXW-1:0]  base,
   output logic [IDXW:0]    rank,
   output logic [IDXW-1:0]  line,
   output logic             found
);
   logic [LINES-1:0] rot;

   always_comb begin
      for (int r = 0; r < LINES; r++) begin
         logic [IDXW-1:0] idx;
         idx    = IDXW'(r) + base;
         rot[r] = vec[idx];
      end
   end

   always_comb begin
      rank = (IDXW+1)'(LINES);
      for (int r = LINES - 1; r >= 0; r--)
         if (rot[r]) rank = (IDXW+1)'(r);
   end

   assign found = (vec != '0);
   assign line  = rank[IDXW-1:0] + base;
endmodule

// File: rtl/irq_rotary_resolver.sv
module irq_rotary_resolver #(
   parameter int LINES        = 8,
   parameter bit IS_MASTER    = 1'b1,
   parameter int CASCADE_LINE = 2,
   localparam int IDXW        = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_clear,
   input  logic [LINES-1:0] req_in,
   input  logic             mask_wr,
   input  logic [LINES-1:0] mask_data,
   input  logic             trig_wr,
   input  logic [LINES-1:0] trig_data,
   input  logic             base_wr,
   input  logic [IDXW-1:0]  base_data,
   input  logic             special_mask,
   input  logic             nested_mode,
   input  logic             ack,
   input  logic             eoi,
   input  logic             eoi_rotate,
   output logic             pend_valid,
   output logic [IDXW-1:0]  pend_irq
);
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (CASCADE_LINE < 0 || CASCADE_LINE >= LINES) begin : g_bad_cascade
      $error("CASCADE_LINE must name one of the request lines");
   end

   logic [LINES-1:0] mask_q, trig_q, isr_q, irr, cand, isr_eff, drop_req, casc_bit;
   logic [IDXW-1:0]  base_q, cand_line, cur_line, eoi_line;
   logic [IDXW:0]    cand_rank, cur_rank, eoi_rank;
   logic             cand_found, cur_found, eoi_found, fire;

   // cascade exclusion exists only on a master instance
   if (IS_MASTER) begin : g_master
      assign casc_bit = LINES'(1) << CASCADE_LINE;
   end else begin : g_slave
      assign casc_bit = '0;
   end

   assign cand    = irr & ~mask_q;
   assign isr_eff = isr_q & ~(special_mask ? mask_q : '0) & ~(nested_mode ? casc_bit : '0);

   irqr_rank #(.LINES(LINES), .IDXW(IDXW)) u_cand (
      .vec(cand), .base(base_q), .rank(cand_rank), .line(cand_line), .found(cand_found));
   irqr_rank #(.LINES(LINES), .IDXW(IDXW)) u_cur (
      .vec(isr_eff), .base(base_q), .rank(cur_rank), .line(cur_line), .found(cur_found));
   irqr_rank #(.LINES(LINES), .IDXW(IDXW)) u_eoi (
      .vec(isr_q), .base(base_q), .rank(eoi_rank), .line(eoi_line), .found(eoi_found));

   assign pend_valid = cand_found && (cand_rank < cur_rank);
   assign pend_irq   = cand_line;
   assign fire       = ack && pend_valid;
   assign drop_req   = fire ? ((LINES'(1) << pend_irq) & ~trig_q) : '0;

   irqr_req_latch #(.LINES(LINES)) u_latch (
      .clk(clk), .rst_n(rst_n), .clr(ctl_clear), .line_in(req_in),
      .trig_sel(trig_q), .drop_req(drop_req), .req_q(irr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       trig_q <= '0;
      else if (trig_wr) trig_q <= trig_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         isr_q  <= '0;
         base_q <= '0;
      end else if (ctl_clear) begin
         mask_q <= '0;
         isr_q  <= '0;
         base_q <= '0;
      end else begin
         if (mask_wr) mask_q <= mask_data;
         if (fire) begin
            isr_q[pend_irq] <= 1'b1;
         end else if (eoi && eoi_found) begin
            isr_q[eoi_line] <= 1'b0;
            if (eoi_rotate) base_q <= eoi_line + IDXW'(1);
         end
         if (base_wr) base_q <= base_data;
      end
   end

   // R4: the reported line is requesting and unmasked
   assert_report_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (!mask_q[pend_irq] && irr[pend_irq]));

   // R6: the reported line is never one that already counts as in service
   assert_not_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> !isr_eff[pend_irq]);

   // R7: an accepted acknowledge puts the reported line in service
   assert_ack_sets_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !ctl_clear) |=> isr_q[$past(pend_irq)]);

   // R8: a rotating end of interrupt moves the base behind the retired line
   assert_eoi_rotates_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && eoi_rotate && !ack && !base_wr && !ctl_clear && eoi_found)
         |=> (base_q == $past(eoi_line) + IDXW'(1)));
endmodule

// File: tb/irq_rotary_resolver_test.sv
module irq_rotary_resolver_test;
   logic       clk = 1'b0;
   logic       rst_n, ctl_clear;
   logic [7:0] req_in, mask_data, trig_data;
   logic       mask_wr, trig_wr, base_wr;
   logic [2:0] base_data;
   logic       special_mask, nested_mode, ack, eoi, eoi_rotate;
   logic       pend_valid;
   logic [2:0] pend_irq;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   irq_rotary_resolver uut (
      .clk(clk), .rst_n(rst_n), .ctl_clear(ctl_clear), .req_in(req_in),
      .mask_wr(mask_wr), .mask_data(mask_data), .trig_wr(trig_wr), .trig_data(trig_data),
      .base_wr(base_wr), .base_data(base_data), .special_mask(special_mask),
      .nested_mode(nested_mode), .ack(ack), .eoi(eoi), .eoi_rotate(eoi_rotate),
      .pend_valid(pend_valid), .pend_irq(pend_irq));

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input bit ev, input logic [2:0] ei);
      checks++;
      if (pend_valid !== ev || (ev && pend_irq !== ei)) begin
         failures++;
         $display("FAIL %s: valid=%0b irq=%0d expected valid=%0b irq=%0d",
                  tag, pend_valid, pend_irq, ev, ei);
      end
   endtask

   task automatic line(input int i, input logic v);
      req_in[i] = v;
      tick();
   endtask

   task automatic do_ack();
      ack = 1'b1; tick(); ack = 1'b0;
   endtask

   task automatic do_eoi(input bit rot);
      eoi = 1'b1; eoi_rotate = rot; tick(); eoi = 1'b0; eoi_rotate = 1'b0;
   endtask

   task automatic wr_mask(input logic [7:0] m);
      mask_wr = 1'b1; mask_data = m; tick(); mask_wr = 1'b0;
   endtask

   task automatic wr_trig(input logic [7:0] t);
      trig_wr = 1'b1; trig_data = t; tick(); trig_wr = 1'b0;
   endtask

   task automatic wr_base(input logic [2:0] b);
      base_wr = 1'b1; base_data = b; tick(); base_wr = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 idle after reset", 1'b0, 3'd0);
      do_ack();
      line(4, 1'b1);
      chk("R7 ack without pending ignored", 1'b1, 3'd4);
      do_ack(); do_eoi(1'b0); line(4, 1'b0);
      chk("R2 cleanup", 1'b0, 3'd0);
   endtask

   task automatic t_edge();
      line(5, 1'b1);
      chk("R2 rising edge requests", 1'b1, 3'd5);
      do_ack();
      chk("R7 acked line leaves", 1'b0, 3'd0);
      do_eoi(1'b0);
      chk("R2 held high no new request", 1'b0, 3'd0);
      line(5, 1'b0); line(5, 1'b1);
      chk("R2 second rise requests", 1'b1, 3'd5);
      line(5, 1'b0);
      chk("R2 low drops request", 1'b0, 3'd0);
   endtask

   task automatic t_level();
      wr_trig(8'h40);
      line(6, 1'b1);
      chk("R3 level request", 1'b1, 3'd6);
      do_ack();
      chk("R6 equal rank held", 1'b0, 3'd0);
      do_eoi(1'b0);
      chk("R3 ack keeps level request", 1'b1, 3'd6);
      line(6, 1'b0);
      chk("R3 level follows low", 1'b0, 3'd0);
      wr_trig(8'h00);
   endtask

   task automatic t_mask();
      req_in[1] = 1'b1; req_in[3] = 1'b1; tick();
      chk("R4 both unmasked", 1'b1, 3'd1);
      wr_mask(8'h02);
      chk("R4 line 1 masked", 1'b1, 3'd3);
      wr_mask(8'h0A);
      chk("R4 all masked", 1'b0, 3'd0);
      wr_mask(8'h00);
      chk("R4 unmasked again", 1'b1, 3'd1);
      do_ack();
      chk("R6 weaker held", 1'b0, 3'd0);
      do_eoi(1'b0);
      chk("R8 eoi releases", 1'b1, 3'd3);
      do_ack(); do_eoi(1'b0);
      req_in[1] = 1'b0; req_in[3] = 1'b0; tick();
      chk("R4 cleanup", 1'b0, 3'd0);
   endtask

   task automatic t_rotate();
      req_in[2] = 1'b1; req_in[6] = 1'b1; tick();
      chk("R5 base 0", 1'b1, 3'd2);
      wr_base(3'd5);
      chk("R5 base 5", 1'b1, 3'd6);
      wr_base(3'd3);
      chk("R5 base 3", 1'b1, 3'd6);
      wr_base(3'd7);
      chk("R5 base 7", 1'b1, 3'd2);
      wr_base(3'd0);
      do_ack(); do_eoi(1'b0); do_ack(); do_eoi(1'b0);
      req_in[2] = 1'b0; req_in[6] = 1'b0; tick();
      chk("R5 cleanup", 1'b0, 3'd0);
   endtask

   task automatic t_nest();
      line(4, 1'b1); do_ack(); line(4, 1'b0); line(4, 1'b1);
      chk("R6 equal rank blocked", 1'b0, 3'd0);
      line(6, 1'b1);
      chk("R6 lower rank blocked", 1'b0, 3'd0);
      line(2, 1'b1);
      chk("R6 higher rank reported", 1'b1, 3'd2);
      do_ack();
      line(3, 1'b1);
      chk("R6 blocked by line 2", 1'b0, 3'd0);
      do_eoi(1'b0);
      chk("R8 eoi retires strongest", 1'b1, 3'd3);
      do_ack(); do_eoi(1'b0);
      chk("R8 line 4 still in service", 1'b0, 3'd0);
      do_eoi(1'b0);
      chk("R8 second eoi", 1'b1, 3'd4);
      do_ack(); do_eoi(1'b0);
      chk("R6 last request", 1'b1, 3'd6);
      do_ack(); do_eoi(1'b0);
      req_in = '0; tick();
      chk("R6 cleanup", 1'b0, 3'd0);
   endtask

   task automatic t_eoi_rot();
      line(1, 1'b1); do_ack(); line(1, 1'b0);
      do_eoi(1'b1);
      req_in[0] = 1'b1; req_in[3] = 1'b1; tick();
      chk("R8 rotated base", 1'b1, 3'd3);
      do_ack(); do_eoi(1'b0);
      chk("R8 next after rotate", 1'b1, 3'd0);
      do_ack(); do_eoi(1'b0);
      req_in = '0; tick(); wr_base(3'd0);
      chk("R8 cleanup", 1'b0, 3'd0);
   endtask

   task automatic t_smask();
      line(3, 1'b1); do_ack(); wr_mask(8'h08);
      line(5, 1'b1);
      chk("R9 off blocks", 1'b0, 3'd0);
      special_mask = 1'b1; tick();
      chk("R9 masked service ignored", 1'b1, 3'd5);
      special_mask = 1'b0; tick();
      chk("R9 off again", 1'b0, 3'd0);
      wr_mask(8'h00); do_eoi(1'b0);
      chk("R9 after eoi", 1'b1, 3'd5);
      do_ack(); do_eoi(1'b0);
      req_in = '0; tick();
      chk("R9 cleanup", 1'b0, 3'd0);
   endtask

   task automatic t_nested();
      line(2, 1'b1); do_ack();
      line(5, 1'b1);
      chk("R10 off blocks", 1'b0, 3'd0);
      nested_mode = 1'b1; tick();
      chk("R10 cascade ignored", 1'b1, 3'd5);
      nested_mode = 1'b0; tick();
      chk("R10 off again", 1'b0, 3'd0);
      do_eoi(1'b0);
      chk("R10 after eoi", 1'b1, 3'd5);
      do_ack(); do_eoi(1'b0);
      req_in = '0; tick();
      chk("R10 cleanup", 1'b0, 3'd0);
   endtask

   task automatic t_clear();
      wr_trig(8'h80); wr_mask(8'h80);
      line(7, 1'b1);
      chk("R4 masked level line", 1'b0, 3'd0);
      wr_base(3'd3);
      ctl_clear = 1'b1; tick(); ctl_clear = 1'b0;
      chk("R1 cleared state", 1'b0, 3'd0);
      tick();
      chk("R1 mask cleared", 1'b1, 3'd7);
      do_ack(); do_eoi(1'b0);
      chk("R11 trigger kept level", 1'b1, 3'd7);
      line(7, 1'b0);
      chk("R11 cleanup", 1'b0, 3'd0);
   endtask

   initial begin
      rst_n = 1'b0; ctl_clear = 1'b0; req_in = '0;
      mask_wr = 1'b0; mask_data = '0; trig_wr = 1'b0; trig_data = '0;
      base_wr = 1'b0; base_data = '0; special_mask = 1'b0; nested_mode = 1'b0;
      ack = 1'b0; eoi = 1'b0; eoi_rotate = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_edge();
      t_level();
      t_mask();
      t_rotate();
      t_nest();
      t_eoi_rot();
      t_smask();
      t_nested();
      t_clear();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule